// File: doc/BRIEF.md
# Strobed Fuse Read Port

This block models a small one-time-programmable fuse array behind a pin-level read interface. Software drives a 16-bit control word over a simple memory-mapped bus. The word carries a chip-select (active low), a load bit, a program-enable-bar bit, a strobe bit and a fuse address. The block decodes that word into a mode. A byte is fetched from the fuse storage only when the strobe rises while the port is in read mode. The fuse contents are fixed at elaboration by a parameter, and the block has no way to burn fuses.

The fetched byte does not appear at once. A latency parameter, counted in clock cycles, stands for the sense delay between the strobe edge and valid data. After that delay the byte lands in a data-out register, which holds its value until the next valid strobe. A driver is expected to set the address, raise the strobe, wait out the latency, read the data-out register and drop the strobe before moving to the next address.

Top module: `fuse_rd_port`

## Requirements
- R1: After a synchronous reset the control register reads 0x0000_0009 (standby: chip-select-bar and program-enable-bar high) and the data-out register reads 0.
- R2: A bus write to offset 0x0 stores bits 15:0 of the write data in the control register. Reading offset 0x0 returns them zero-extended, and bits 31:16 of the write are dropped.
- R3: Read mode is the control value with bit 0 (chip-select-bar) = 0, bit 2 (load) = 1 and bit 3 (program-enable-bar) = 1. A control write that sets bit 1 (strobe) while the stored strobe is 0, and whose new value is in read mode, captures the fuse byte at the address in bits 15:6 of that write.
- R4: The captured byte reaches the data-out register (offset 0x4) exactly LATENCY clock edges after the capturing write's edge. Before that edge the register keeps its previous value.
- R5: A strobe rise written in any mode other than read mode (standby, chip-select-bar high, or load low) leaves the data-out register unchanged.
- R6: Writing the strobe as 1 when it is already 1 captures nothing, even when the address changes.
- R7: A fuse address of 32 or more returns 0x00.
- R8: Bus reads are registered. The read data shows the register's value as it stood just before the clock edge of the read. A read that falls on the edge where a capture lands returns the old data-out value.
- R9: Writes to offset 0x4 or to any offset other than 0x0 have no effect. Reads of offsets other than 0x0 and 0x4 return 0.
- R10: Strobes issued closer together than LATENCY cycles each deliver their own byte, in issue order, each LATENCY edges after its own strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
A capture can land in data-out on the same edge that a bus read samples data-out, and a new strobe can be written while an earlier capture is still in flight. The bench reads data-out on every cycle after each strobe, so some read always meets the landing edge. A behavioural reference model built from a queue of due cycles then judges whether the old or the new byte was returned. Back-to-back strobes spaced more tightly than the latency check that each byte surfaces on its own edge and in order.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    localparam int BUS_W      = 32;
    localparam int CTRL_W     = 16;
    localparam int FADDR_W    = 10;
    localparam int OFFS_CTRL  = 0;
    localparam int OFFS_DOUT  = 4;

    localparam logic [CTRL_W-1:0] CTRL_RST = 16'h0009;

    localparam logic [255:0] FUSE_DEFAULT =
        256'h1F2E3D4C_5B6A7988_97A6B5C4_D3E2F100_0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;

    typedef struct packed {
        logic [FADDR_W-1:0] addr;
        logic [1:0]         spare;
        logic               pgm_n;
        logic               load;
        logic               strobe;
        logic               cs_n;
    } ctrl_t;

    function automatic logic in_read_mode(ctrl_t c);
        return !c.cs_n && c.load && c.pgm_n;
    endfunction

endpackage

// File: rtl/fuse_store.sv
module fuse_store
    import fuse_pkg::*;
#(
    parameter int NUM = 32,
    parameter logic [8*NUM-1:0] INIT = FUSE_DEFAULT
) (
    input  logic [FADDR_W-1:0] addr,
    output logic [7:0]         data
);
    localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1;

    logic [7:0] cells [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_cell
        assign cells[g] = INIT[8*g +: 8];
    end

    logic [IDX_W-1:0] idx;
    assign idx = addr[IDX_W-1:0];

    always_comb begin
        if (32'(addr) < NUM) data = cells[idx];
        else                 data = 8'h00;
    end
endmodule

// File: rtl/fuse_strobe_seq.sv
module fuse_strobe_seq
    import fuse_pkg::*;
#(
    parameter int LAT = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ctrl,
    input  ctrl_t      wdata,
    input  logic [7:0] fuse_byte,
    output ctrl_t      ctrl_q,
    output logic [7:0] dout
);
    logic             cap;
    logic [LAT-1:0]   vld;
    logic [7:0]       dat [LAT];
    logic             vld_any;

    assign cap     = wr_ctrl && wdata.strobe && !ctrl_q.strobe && in_read_mode(wdata);
    assign vld_any = |vld;

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= ctrl_t'(CTRL_RST);
        else if (wr_ctrl) ctrl_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            for (int i = 0; i < LAT; i++) dat[i] <= 8'h00;
        end else begin
            vld[0] <= cap;
            dat[0] <= fuse_byte;
            for (int i = 1; i < LAT; i++) begin
                vld[i] <= vld[i-1];
                dat[i] <= dat[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dout <= 8'h00;
        else if (vld[LAT-1]) dout <= dat[LAT-1];
    end

    // R4: data-out moves only when a capture is in flight
    p_dout_source_r4: assert property (@(posedge clk) disable iff (rst)
        (dout != $past(dout)) |-> $past(vld_any));

    // R2: control register takes the written word
    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (ctrl_q == $past(wdata)));

    // R5: no capture enters the pipe outside read mode
    p_no_cap_outside_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !in_read_mode(wdata)) |=> !vld[0]);

    // R6: a strobe already high starts nothing
    p_no_cap_held_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && ctrl_q.strobe) |=> !vld[0]);
endmodule

// File: rtl/fuse_rd_port.sv
module fuse_rd_port
    import fuse_pkg::*;
#(
    parameter int NUM    = 32,
    parameter int LAT    = 6,
    parameter int ADDR_W = 4,
    parameter logic [8*NUM-1:0] INIT = FUSE_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata
);
    logic       hit_ctrl, hit_dout, wr_ctrl, rd_req;
    ctrl_t      wword, ctrl_q;
    logic [7:0] fuse_byte, dout;
    logic       unused_hi;

    assign hit_ctrl  = bus_addr == ADDR_W'(OFFS_CTRL);
    assign hit_dout  = bus_addr == ADDR_W'(OFFS_DOUT);
    assign wr_ctrl   = bus_sel && bus_wr && hit_ctrl;
    assign rd_req    = bus_sel && !bus_wr;
    assign wword     = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    assign unused_hi = ^bus_wdata[BUS_W-1:CTRL_W];

    fuse_store #(.NUM(NUM), .INIT(INIT)) u_store (
        .addr (wword.addr),
        .data (fuse_byte)
    );

    fuse_strobe_seq #(.LAT(LAT)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (wr_ctrl),
        .wdata     (wword),
        .fuse_byte (fuse_byte),
        .ctrl_q    (ctrl_q),
        .dout      (dout)
    );

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else if (rd_req) begin
            if (hit_ctrl)      bus_rdata <= BUS_W'(ctrl_q);
            else if (hit_dout) bus_rdata <= BUS_W'(dout);
            else               bus_rdata <= '0;
        end
    end

    // R8: control read returns the pre-edge register value
    p_rd_ctrl_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_req && hit_ctrl) |=> (bus_rdata == BUS_W'($past(ctrl_q))));

    // R9: unused offsets read as zero
    p_rd_unused_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !hit_ctrl && !hit_dout) |=> (bus_rdata == '0));
endmodule

// File: tb/fuse_rd_port_bench.sv
module fuse_rd_port_bench;
    localparam int LAT = 4;
    localparam logic [255:0] INIT =
        256'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F_00112233_44556677_8899AABB_CCDDEEFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    always #5 clk = ~clk;

    fuse_rd_port #(.NUM(32), .LAT(LAT), .ADDR_W(4), .INIT(INIT)) u_fuse_rd_port (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;
    logic [15:0] m_ctrl;
    logic [7:0]  m_dout;
    logic [31:0] m_rdata;
    int          due_q[$];
    logic [7:0]  byte_q[$];

    function automatic logic [7:0] fuse_of(int a);
        return (a < 32) ? INIT[8*a +: 8] : 8'h00;
    endfunction

    function automatic bit rd_mode(logic [15:0] w);
        return w[0] == 1'b0 && w[2] && w[3];
    endfunction

    task automatic model_edge(bit r, bit s, bit w, logic [3:0] a, logic [31:0] d);
        if (r) begin
            m_ctrl = 16'h0009; m_dout = 0; m_rdata = 0;
            due_q.delete(); byte_q.delete();
            return;
        end
        if (s && !w) m_rdata = (a == 0) ? {16'h0, m_ctrl} : (a == 4) ? {24'h0, m_dout} : 32'h0;
        while (due_q.size() > 0 && due_q[0] == cyc) begin
            void'(due_q.pop_front());
            m_dout = byte_q.pop_front();
        end
        if (s && w && a == 0) begin
            if (d[1] && !m_ctrl[1] && rd_mode(d[15:0])) begin
                due_q.push_back(cyc + LAT);
                byte_q.push_back(fuse_of(int'(d[15:6])));
            end
            m_ctrl = d[15:0];
        end
    endtask

    task automatic step(bit s, bit w, logic [3:0] a, logic [31:0] d, string tag);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        cyc++;
        model_edge(rst, s, w, a, d);
        @(negedge clk);
        total++;
        if (bus_rdata !== m_rdata) begin
            bad++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, bus_rdata, m_rdata);
        end
    endtask

    task automatic wctrl(logic [31:0] d, string tag);
        step(1, 1, 4'h0, d, tag);
    endtask

    task automatic rd_dout(int n, string tag);
        for (int i = 0; i < n; i++) step(1, 0, 4'h4, 32'h0, tag);
    endtask

    function automatic logic [31:0] cw(int a, logic [3:0] bits);
        return (32'(a) << 6) | 32'(bits);
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(0, 0, 4'h0, 32'h0, "R1 reset");
        rst = 1'b0;
        step(1, 0, 4'h0, 32'h0, "R1 ctrl reset value");
        step(1, 0, 4'h4, 32'h0, "R1 dout reset value");

        // R5: strobe rise in standby, csb high, and load low
        wctrl(cw(5, 4'b1011), "R5 standby strobe");
        rd_dout(LAT + 2, "R5 standby no data");
        wctrl(cw(5, 4'b1001), "R5 drop");
        wctrl(cw(5, 4'b1111), "R5 csb high strobe");
        rd_dout(LAT + 2, "R5 csb high no data");
        wctrl(cw(5, 4'b1000), "R5 drop");
        wctrl(cw(5, 4'b1010), "R5 load low strobe");
        rd_dout(LAT + 2, "R5 load low no data");

        // R3/R4/R8: read mode capture of address 0, read every cycle
        wctrl(cw(0, 4'b1100), "R3 enter read");
        wctrl(cw(0, 4'b1110), "R3 strobe addr0");
        rd_dout(LAT + 2, "R4 R8 latency addr0");
        wctrl(32'hABCD_0000 | cw(31, 4'b1100), "R2 drop with hi bits");
        step(1, 0, 4'h0, 32'h0, "R2 ctrl readback");
        wctrl(cw(31, 4'b1110), "R3 strobe addr31");
        rd_dout(LAT + 2, "R4 addr31");

        // R6: strobe held high with new address
        wctrl(cw(7, 4'b1110), "R6 held strobe");
        rd_dout(LAT + 2, "R6 no new data");
        wctrl(cw(7, 4'b1100), "R6 drop");

        // R7: out of range
        wctrl(cw(40, 4'b1110), "R7 strobe addr40");
        rd_dout(LAT + 2, "R7 zero data");
        wctrl(cw(40, 4'b1100), "R7 drop");

        // R10: strobes closer than the latency
        wctrl(cw(3, 4'b1110), "R10 strobe a3");
        wctrl(cw(3, 4'b1100), "R10 drop");
        wctrl(cw(9, 4'b1110), "R10 strobe a9");
        wctrl(cw(9, 4'b1100), "R10 drop");
        wctrl(cw(17, 4'b1110), "R10 strobe a17");
        rd_dout(LAT + 3, "R10 ordered delivery");

        // R9: writes to data-out and unused offsets, read of unused
        step(1, 1, 4'h4, 32'h0000_0055, "R9 write dout");
        step(1, 1, 4'h8, 32'h0000_0000, "R9 write unused");
        rd_dout(2, "R9 dout unchanged");
        step(1, 0, 4'h0, 32'h0, "R9 ctrl unchanged");
        step(1, 0, 4'h8, 32'h0, "R9 unused reads zero");
        step(0, 0, 4'h0, 32'h0, "R8 idle holds rdata");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule